// File: doc/BRIEF.md
# Masked packed half-precision square root

The block takes a packed vector of 16-bit half-precision values and returns, for each lane, the correctly rounded square root. The vector is `VLEN` bits wide (128, 256 or 512), so it holds `VLEN/16` lanes. A single bit-serial square-root engine is shared by all lanes. The lanes are processed in ascending order, and each lane takes one slot of the engine before the next one starts.

Every lane is governed by a write mask. A masked-off lane keeps its previous destination value, or is cleared to zero when zeroing is selected. A broadcast select feeds element 0 of the source to every active lane in place of that lane's own element. The rounding mode comes from a default field. When the vector is 512 bits wide, a per-operation static mode can replace the default. A one-cycle `start` pulse captures every input. A one-cycle `done` pulse reports completion. Three sticky exception flags gather the events raised by the lanes of that operation.

Top module: `hsqrt_vec`

## Requirements
- R1: With default parameters the vector has 32 lanes (`VLEN/16`). Each computed lane with a positive finite non-zero input holds the square root of that input, correctly rounded to half precision.
- R2: With `mask_en`=1 and `zero_en`=0, a lane whose `mask` bit is 0 keeps the value that the lane had on `prev_dest` when `start` was sampled.
- R3: With `mask_en`=1 and `zero_en`=1, a lane whose `mask` bit is 0 becomes 16'h0000.
- R4: With `mask_en`=0, every lane is computed regardless of `mask`.
- R5: With `bcast`=1, every active lane uses source element 0 (bits 15:0) as its input.
- R6: Rounding mode codes are 0 = nearest-even, 1 = toward minus infinity, 2 = toward plus infinity and 3 = toward zero. With the default `VLEN` of 512, `rm_static_en`=1 selects `rm_static`; otherwise `rm_dflt` applies.
- R7: A negative non-zero input, including minus infinity, gives 16'h7E00 and sets Invalid. A signalling NaN (exponent 31, fraction non-zero, fraction bit 9 = 0) also gives 16'h7E00 and sets Invalid. A quiet NaN passes through unchanged. Each of +0, -0 and +infinity returns itself. No input named in this requirement raises Precision.
- R8: A subnormal input (exponent 0, fraction non-zero), of either sign, sets Denormal. A positive subnormal is normalised, and its root is a normal number.
- R9: Precision is set when some computed lane's root is not exact.
- R10: `flags` is {Precision, Denormal, Invalid} in bits 2:0. The flags are cleared when an operation starts. They then collect events only from lanes whose mask bit is active.
- R11: A computed lane (active, with a positive finite non-zero input) takes 14 cycles. Any other lane takes 1 cycle. `done` is high for exactly one cycle, after `N` clock edges following the edge that samples `start`, where `N` is the sum of the lane costs. After that, `dest` and `flags` hold until the next start.
- R12: A `start` pulse that arrives while an operation is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that captures all inputs |
| src | input | VLEN | Packed half-precision source vector |
| prev_dest | input | VLEN | Previous destination value, used for merged lanes |
| mask | input | VLEN/16 | Per-lane write mask |
| mask_en | input | 1 | 1 = apply the mask, 0 = compute every lane |
| zero_en | input | 1 | 1 = zero masked-off lanes, 0 = keep their previous value |
| bcast | input | 1 | 1 = every lane takes element 0 |
| rm_dflt | input | 2 | Default rounding mode |
| rm_static_en | input | 1 | Selects the static rounding mode (512-bit width only) |
| rm_static | input | 2 | Static rounding mode |
| dest | output | VLEN | Destination vector |
| flags | output | 3 | {Precision, Denormal, Invalid} |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall on the same clock edge: the write of the last lane, with its flag contribution, and the `done` pulse. A `start` that arrives while lanes are still in progress can also coincide with the sequencer moving from one lane to the next. The bench provokes the first case by ending operations with a computed lane on some runs and with a masked-off or special lane on others. It provokes the second by raising `start` in the middle of an operation, with different inputs on the pins. Each run is judged against a behavioural model that predicts the cycle of `done`. The model requires `done` to be low on every other cycle, and it predicts every lane and flag from an exact integer search for the rounded root.

// File: rtl/hsqrt_pkg.sv
// Shared constants for the packed half-precision square root.
// Assumes the rounding-mode code values listed in the brief.
package hsqrt_pkg;
    localparam logic [1:0] RM_NE = 2'd0;   // nearest, ties to even
    localparam logic [1:0] RM_DN = 2'd1;   // toward minus infinity
    localparam logic [1:0] RM_UP = 2'd2;   // toward plus infinity
    localparam logic [1:0] RM_TZ = 2'd3;   // toward zero

    localparam int FLG_INV = 0;
    localparam int FLG_DEN = 1;
    localparam int FLG_PRC = 2;

    localparam int ROOT_STEPS = 12;        // 11 significand bits plus a guard bit
endpackage

// File: rtl/hsqrt_prep.sv
// Classifies one half-precision operand and prepares the radicand.
// Special operands get their final result here. A positive finite
// non-zero operand is normalised, its exponent is made even and the
// biased result exponent is derived. Purely combinational.
module hsqrt_prep (
    input  logic [15:0] h,
    output logic        special,
    output logic [15:0] spec_res,
    output logic        inv,
    output logic        den,
    output logic [23:0] rad,
    output logic [4:0]  exp_b
);
    logic        sgn;
    logic [4:0]  ex;
    logic [9:0]  fr;
    logic [3:0]  msb;
    logic [3:0]  sh;
    logic [10:0] man;
    logic [11:0] manp;
    logic signed [6:0] e, e_ev, eh;
    logic        odd;

    assign sgn = h[15];
    assign ex  = h[14:10];
    assign fr  = h[9:0];

    // Leading one position of the fraction, used to normalise subnormals
    always_comb begin
        msb = 4'd0;
        for (int k = 0; k < 10; k++) begin
            if (fr[k]) msb = 4'(k);
        end
    end

    // Normalised significand, even exponent and result exponent
    always_comb begin
        sh = 4'd10 - msb;
        if (ex == 5'd0) begin
            man = 11'(fr) << sh;
            e   = -7'sd14 - $signed({3'b000, sh});
        end else begin
            man = {1'b1, fr};
            e   = $signed({2'b00, ex}) - 7'sd15;
        end
        odd   = e[0];
        manp  = odd ? {man, 1'b0} : {1'b0, man};
        e_ev  = e - $signed({6'd0, odd});
        eh    = e_ev >>> 1;
        exp_b = 5'(eh + 7'sd15);
    end

    // Special-case classification and result
    always_comb begin
        den      = (ex == 5'd0) && (fr != 10'd0);
        special  = 1'b1;
        spec_res = h;
        inv      = 1'b0;
        rad      = {manp, 12'd0};
        if (ex == 5'd31 && fr != 10'd0) begin
            if (!fr[9]) begin
                spec_res = 16'h7E00;
                inv      = 1'b1;
            end
        end else if (sgn && (h[14:0] != 15'd0)) begin
            spec_res = 16'h7E00;
            inv      = 1'b1;
        end else if (h[14:0] == 15'd0 || ex == 5'd31) begin
            spec_res = h;
        end else begin
            special = 1'b0;
        end
    end
endmodule

// File: rtl/hsqrt_iter.sv
// Bit-serial restoring square-root engine. Loading clears the partial
// root and the remainder. Each step then takes two radicand bits and
// yields one root bit. Assumes the caller issues exactly STEPS steps
// after a load before it reads the root.
module hsqrt_iter #(
    parameter int STEPS = 12,
    localparam int RADW = 2 * STEPS,
    localparam int REMW = STEPS + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  logic [RADW-1:0] rad,
    output logic [STEPS-1:0] root,
    output logic            rem_nz
);
    logic [RADW-1:0] x;
    logic [REMW-1:0] rem;
    logic [REMW+1:0] tmp, trial;
    logic            ge;

    // One recurrence step: shift in two bits, then try to subtract 4q+1
    always_comb begin
        tmp   = {rem, x[RADW-1 -: 2]};
        trial = {2'b00, root, 2'b01};
        ge    = (tmp >= trial);
    end

    // Engine state: remaining radicand, partial remainder, partial root
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x    <= '0;
            rem  <= '0;
            root <= '0;
        end else if (load) begin
            x    <= rad;
            rem  <= '0;
            root <= '0;
        end else if (step) begin
            x    <= x << 2;
            rem  <= REMW'(ge ? tmp - trial : tmp);
            root <= {root[STEPS-2:0], ge};
        end
    end

    assign rem_nz = |rem;
endmodule

// File: rtl/hsqrt_round.sv
// Rounds a 12-bit root (the normalised significand plus a guard bit, with a
// sticky bit taken from the remainder) and packs a positive half-precision
// result. Assumes the root is normalised (MSB set). Combinational.
module hsqrt_round
    import hsqrt_pkg::*;
(
    input  logic [10:0] root_lo,
    input  logic        rem_nz,
    input  logic [4:0]  exp_b,
    input  logic [1:0]  rm,
    output logic [15:0] res,
    output logic        inexact
);
    logic        g, inc, carry;
    logic [9:0]  frac;

    // Increment decision per rounding mode, for a positive value
    always_comb begin
        g = root_lo[0];
        case (rm)
            RM_NE:   inc = g & (rem_nz | root_lo[1]);
            RM_UP:   inc = g | rem_nz;
            default: inc = 1'b0;
        endcase
        {carry, frac} = {1'b0, root_lo[10:1]} + 11'(inc);
        res     = {1'b0, exp_b + {4'd0, carry}, frac};
        inexact = g | rem_nz;
    end
endmodule

// File: rtl/hsqrt_vec.sv
// Masked packed half-precision square root. Captures its inputs on start,
// visits the lanes in ascending order through one shared root engine and
// pulses done after the last lane. Assumes start is a single-cycle pulse.
// A start that arrives while the block is busy is ignored.
module hsqrt_vec
    import hsqrt_pkg::*;
#(
    parameter int VLEN = 512,
    localparam int LANES = VLEN / 16,
    localparam int IW = $clog2(LANES),
    localparam int CW = $clog2(ROOT_STEPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VLEN-1:0]  src,
    input  logic [VLEN-1:0]  prev_dest,
    input  logic [LANES-1:0] mask,
    input  logic             mask_en,
    input  logic             zero_en,
    input  logic             bcast,
    input  logic [1:0]       rm_dflt,
    input  logic             rm_static_en,
    input  logic [1:0]       rm_static,
    output logic [VLEN-1:0]  dest,
    output logic [2:0]       flags,
    output logic             done
);
    typedef enum logic [1:0] {ST_IDLE, ST_LANE, ST_RUN, ST_FIN} state_t;

    state_t           st;
    logic [IW-1:0]    idx;
    logic [CW-1:0]    cnt;
    logic [VLEN-1:0]  src_q;
    logic [LANES-1:0] mask_q;
    logic             zero_q, bcast_q;
    logic [1:0]       rm_q, rm_eff;
    logic [4:0]       exp_q;

    logic [15:0]      cur;
    logic             p_special, p_inv, p_den;
    logic [15:0]      p_spec;
    logic [23:0]      p_rad;
    logic [4:0]       p_exp;
    logic [ROOT_STEPS-1:0] root_w;
    logic             rem_nz_w;
    logic [15:0]      res_w;
    logic             inex_w;
    logic             lane_on, eng_load, lane_end, last;
    logic             idle_w, fin_w;

    // Static rounding override exists only at the widest vector length
    generate
        if (VLEN == 512) begin : g_rm_static
            assign rm_eff = rm_static_en ? rm_static : rm_dflt;
        end else begin : g_rm_fixed
            assign rm_eff = rm_dflt;
        end
    endgenerate

    // Operand of the lane being visited
    assign cur      = bcast_q ? src_q[15:0] : src_q[{idx, 4'b0000} +: 16];
    assign lane_on  = mask_q[idx];
    assign eng_load = (st == ST_LANE) && lane_on && !p_special;
    assign lane_end = ((st == ST_LANE) && !(lane_on && !p_special)) || (st == ST_FIN);
    assign last     = (idx == IW'(LANES - 1));
    assign idle_w   = (st == ST_IDLE);
    assign fin_w    = (st == ST_FIN);

    hsqrt_prep u_prep (
        .h(cur), .special(p_special), .spec_res(p_spec), .inv(p_inv),
        .den(p_den), .rad(p_rad), .exp_b(p_exp)
    );

    hsqrt_iter #(.STEPS(ROOT_STEPS)) u_iter (
        .clk(clk), .rst_n(rst_n), .load(eng_load), .step(st == ST_RUN),
        .rad(p_rad), .root(root_w), .rem_nz(rem_nz_w)
    );

    hsqrt_round u_round (
        .root_lo(root_w[10:0]), .rem_nz(rem_nz_w), .exp_b(exp_q), .rm(rm_q),
        .res(res_w), .inexact(inex_w)
    );

    // Sequencer: capture, per-lane writes, flag collection, done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            idx     <= '0;
            cnt     <= '0;
            src_q   <= '0;
            mask_q  <= '0;
            zero_q  <= 1'b0;
            bcast_q <= 1'b0;
            rm_q    <= RM_NE;
            exp_q   <= '0;
            dest    <= '0;
            flags   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        src_q   <= src;
                        mask_q  <= mask_en ? mask : '1;
                        zero_q  <= zero_en;
                        bcast_q <= bcast;
                        rm_q    <= rm_eff;
                        dest    <= prev_dest;
                        flags   <= '0;
                        idx     <= '0;
                        st      <= ST_LANE;
                    end
                end
                ST_LANE: begin
                    if (!lane_on) begin
                        if (zero_q) dest[{idx, 4'b0000} +: 16] <= 16'h0000;
                    end else if (p_special) begin
                        dest[{idx, 4'b0000} +: 16] <= p_spec;
                        flags[FLG_INV] <= flags[FLG_INV] | p_inv;
                        flags[FLG_DEN] <= flags[FLG_DEN] | p_den;
                    end else begin
                        exp_q <= p_exp;
                        flags[FLG_DEN] <= flags[FLG_DEN] | p_den;
                        cnt   <= CW'(ROOT_STEPS - 1);
                        st    <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (cnt == '0) st <= ST_FIN;
                    else           cnt <= cnt - 1'b1;
                end
                ST_FIN: begin
                    dest[{idx, 4'b0000} +: 16] <= res_w;
                    flags[FLG_PRC] <= flags[FLG_PRC] | inex_w;
                end
                default: st <= ST_IDLE;
            endcase
            if (lane_end) begin
                if (last) begin
                    done <= 1'b1;
                    st   <= ST_IDLE;
                end else begin
                    idx <= idx + 1'b1;
                    st  <= ST_LANE;
                end
            end
        end
    end
endmodule

// File: rtl/hsqrt_chk.sv
// Temporal checks for hsqrt_vec, attached through bind.
module hsqrt_chk #(
    parameter int VLEN = 512
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            done,
    input logic            idle,
    input logic            fin,
    input logic [11:0]     root,
    input logic [15:0]     res,
    input logic [VLEN-1:0] dest,
    input logic [2:0]      flags
);
    // R11: done lasts exactly one cycle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: done is raised only as a busy operation ends
    a_r11_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (idle && !$past(idle)));

    // R11: destination holds while idle without a start
    a_r11_dest_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !start) |=> $stable(dest));

    // R10: flags hold while idle without a start
    a_r10_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !start) |=> $stable(flags));

    // R1: the engine delivers a normalised root when a lane finishes
    a_r1_root_norm: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> root[11]);

    // R8: a computed root is never subnormal
    a_r8_no_subnormal: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> (res[14:10] != 5'd0));
endmodule

bind hsqrt_vec hsqrt_chk #(.VLEN(VLEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .idle(idle_w),
    .fin(fin_w), .root(root_w), .res(res_w), .dest(dest), .flags(flags)
);

// File: tb/sim_hsqrt_vec.sv
`timescale 1ns/1ps
// Bench for hsqrt_vec. It predicts every lane through an exact integer
// search, predicts the done cycle from lane costs and checks each clock.
module sim_hsqrt_vec;
    localparam int VLEN  = 512;
    localparam int LANES = VLEN / 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [VLEN-1:0]  src = '0, prev_dest = '0;
    logic [LANES-1:0] mask = '0;
    logic             mask_en = 1'b0, zero_en = 1'b0, bcast = 1'b0;
    logic [1:0]       rm_dflt = 2'd0, rm_static = 2'd0;
    logic             rm_static_en = 1'b0;
    logic [VLEN-1:0]  dest;
    logic [2:0]       flags;
    logic             done;

    int errors = 0;
    int checks = 0;

    logic [15:0]      t_src [LANES];
    logic [15:0]      t_prev[LANES];
    logic [LANES-1:0] t_mask;
    logic             t_men, t_zero, t_bc, t_rse;
    logic [1:0]       t_rmd, t_rms;

    hsqrt_vec #(.VLEN(VLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .src(src), .prev_dest(prev_dest),
        .mask(mask), .mask_en(mask_en), .zero_en(zero_en), .bcast(bcast),
        .rm_dflt(rm_dflt), .rm_static_en(rm_static_en), .rm_static(rm_static),
        .dest(dest), .flags(flags), .done(done)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Value times 2^24 as an integer (exact for every finite code)
    function automatic logic [127:0] v24(input logic [15:0] c);
        if (c[14:10] == 5'd0) return 128'(c[9:0]);
        return 128'({1'b1, c[9:0]}) << (c[14:10] - 5'd1);
    endfunction

    // Correctly rounded root of a positive finite non-zero code
    task automatic ref_root(input logic [15:0] a, input logic [1:0] rm,
                            output logic [15:0] r, output bit px);
        logic [127:0] t, slo, m;
        int lo, hi, mid;
        t  = v24(a) << 24;
        lo = 0;
        hi = 16'h7BFF;
        while (lo < hi) begin
            mid = (lo + hi + 1) / 2;
            if (v24(16'(mid)) * v24(16'(mid)) <= t) lo = mid;
            else hi = mid - 1;
        end
        slo = v24(16'(lo)) * v24(16'(lo));
        px  = (slo != t);
        r   = 16'(lo);
        if (px) begin
            if (rm == 2'd2) r = 16'(lo + 1);
            else if (rm == 2'd0) begin
                m = (v24(16'(lo)) + v24(16'(lo + 1))) * (v24(16'(lo)) + v24(16'(lo + 1)));
                if ((t << 2) > m) r = 16'(lo + 1);
                else if ((t << 2) == m && lo[0]) r = 16'(lo + 1);
            end
        end
    endtask

    // Expected lane result, flags {P,D,I} and whether it uses the engine
    task automatic ref_lane(input logic [15:0] h, input logic [1:0] rm,
                            output logic [15:0] r, output logic [2:0] fl, output bit comp);
        bit px;
        fl = 3'b000; comp = 1'b0; r = h;
        if (h[14:10] == 5'd0 && h[9:0] != 10'd0) fl[1] = 1'b1;
        if (h[14:10] == 5'd31 && h[9:0] != 10'd0) begin
            if (!h[9]) begin r = 16'h7E00; fl[0] = 1'b1; end
        end else if (h[15] && h[14:0] != 15'd0) begin
            r = 16'h7E00; fl[0] = 1'b1;
        end else if (h[14:0] == 15'd0 || h[14:10] == 5'd31) begin
            r = h;
        end else begin
            comp = 1'b1;
            ref_root(h, rm, r, px);
            fl[2] = px;
        end
    endtask

    // Run one operation; inj > 0 raises a stray start at that busy cycle
    task automatic run_op(input string tag, input int inj);
        logic [15:0] exp_l [LANES];
        logic [2:0]  exp_f, fl;
        logic [15:0] r;
        logic [VLEN-1:0] snap;
        logic [1:0]  rm;
        bit comp, act, lat_bad;
        int lat;
        rm = t_rse ? t_rms : t_rmd;
        exp_f = 3'b000;
        lat = 0;
        for (int i = 0; i < LANES; i++) begin
            act = t_men ? t_mask[i] : 1'b1;
            if (act) begin
                ref_lane(t_bc ? t_src[0] : t_src[i], rm, r, fl, comp);
                exp_l[i] = r;
                exp_f |= fl;
                lat += comp ? 14 : 1;
            end else begin
                exp_l[i] = t_zero ? 16'h0000 : t_prev[i];
                lat += 1;
            end
        end
        @(negedge clk);
        for (int i = 0; i < LANES; i++) begin
            src[i*16 +: 16]       = t_src[i];
            prev_dest[i*16 +: 16] = t_prev[i];
        end
        mask = t_mask; mask_en = t_men; zero_en = t_zero; bcast = t_bc;
        rm_dflt = t_rmd; rm_static_en = t_rse; rm_static = t_rms;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat_bad = (done !== 1'b0);
        for (int k = 1; k <= lat; k++) begin
            @(negedge clk);
            if (done !== (k == lat)) lat_bad = 1'b1;
            if (inj > 0 && k == inj) begin
                src = '1; prev_dest = '0; mask = '0; mask_en = 1'b0;
                zero_en = 1'b1; bcast = 1'b1; rm_static_en = 1'b1; rm_static = 2'd2;
                start = 1'b1;
            end
            if (inj > 0 && k == inj + 1) start = 1'b0;
        end
        chk(!lat_bad, "R11", {tag, " done cycle"}, 32'(lat), 32'(lat));
        for (int i = 0; i < LANES; i++)
            chk(dest[i*16 +: 16] === exp_l[i], tag, $sformatf("lane %0d", i),
                32'(dest[i*16 +: 16]), 32'(exp_l[i]));
        chk(flags === exp_f, tag, "flags", 32'(flags), 32'(exp_f));
        snap = dest;
        @(negedge clk);
        chk(done === 1'b0 && dest === snap, "R11", {tag, " hold after done"},
            32'(done), 32'(0));
    endtask

    function automatic logic [15:0] rnd_pos();
        return {1'b0, 5'(1 + ($urandom % 30)), 10'($urandom)};
    endfunction

    function automatic logic [15:0] rnd_any();
        int s;
        s = $urandom % 10;
        case (s)
            0: return 16'h7C01;
            1: return 16'h7E33;
            2: return 16'h8000 | 16'(rnd_pos());
            3: return {6'd0, 10'($urandom) | 10'd1};
            default: return rnd_pos();
        endcase
    endfunction

    task automatic defaults();
        for (int i = 0; i < LANES; i++) begin
            t_src[i]  = rnd_pos();
            t_prev[i] = 16'($urandom);
        end
        t_mask = '1; t_men = 1'b1; t_zero = 1'b0; t_bc = 1'b0;
        t_rmd = 2'd0; t_rse = 1'b0; t_rms = 2'd0;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dest === '0, "R11", "reset dest", 32'(dest[31:0]), 32'(0));
        chk(flags === 3'b000, "R10", "reset flags", 32'(flags), 32'(0));
        chk(done === 1'b0, "R11", "reset done", 32'(done), 32'(0));

        // R1 and R9: all lanes active, exact and inexact roots
        defaults();
        t_src[0] = 16'h4400; t_src[1] = 16'h3C00; t_src[2] = 16'h4000;
        t_src[3] = 16'h7BFF; t_src[4] = 16'h0400; t_src[5] = 16'h4C00;
        run_op("R1", 0);
        defaults();
        for (int i = 0; i < LANES; i++) t_src[i] = {1'b0, 5'(15 + i % 4), 10'd0};
        run_op("R9", 0);

        // R7: special operands
        defaults();
        t_src[0] = 16'h0000; t_src[1] = 16'h8000; t_src[2] = 16'h7C00;
        t_src[3] = 16'hFC00; t_src[4] = 16'hBC00; t_src[5] = 16'h7C01;
        t_src[6] = 16'h7E55; t_src[7] = 16'hFE00; t_src[31] = 16'h7D00;
        run_op("R7", 0);
        defaults();
        for (int i = 0; i < LANES; i++) t_src[i] = (i % 2) ? 16'h0000 : 16'h7E01;
        run_op("R7", 0);

        // R8: subnormal operands of both signs
        defaults();
        t_src[0] = 16'h0001; t_src[1] = 16'h03FF; t_src[2] = 16'h0200;
        t_src[3] = 16'h8001; t_src[4] = 16'h0155; t_src[31] = 16'h0002;
        run_op("R8", 0);

        // R2: merge masking
        defaults();
        t_mask = 32'hA5A5_3C0F;
        run_op("R2", 0);

        // R3: zero masking
        defaults();
        t_mask = 32'hA5A5_3C0F; t_zero = 1'b1;
        run_op("R3", 0);

        // R4: mask disabled overrides an all-zero mask
        defaults();
        t_mask = '0; t_men = 1'b0; t_zero = 1'b1;
        run_op("R4", 0);

        // R5: broadcast of element 0; other elements would raise Invalid
        defaults();
        t_src[0] = 16'h4200;
        for (int i = 1; i < LANES; i++) t_src[i] = 16'h7C01;
        t_mask = 32'h0F0F_00F1;
        run_op("R5", 0);

        // R6: each static mode overriding a different default, then the default alone
        for (int m = 0; m < 4; m++) begin
            defaults();
            t_rse = 1'b1; t_rms = 2'(m); t_rmd = 2'(3 - m);
            run_op("R6", 0);
        end
        defaults();
        t_rse = 1'b0; t_rms = 2'd2; t_rmd = 2'd3;
        run_op("R6", 0);

        // R10: flag-raising operands only on masked-off lanes
        defaults();
        for (int i = 0; i < LANES; i++) t_src[i] = (i % 2) ? 16'h7C01 : 16'h0001;
        t_src[0] = 16'h4400; t_src[2] = 16'h4C00;
        t_mask = 32'h0000_0005;
        run_op("R10", 0);

        // R12: stray start while busy
        defaults();
        t_mask = 32'h8000_0101;
        run_op("R12", 3);

        // Mixed random operations
        for (int n = 0; n < 6; n++) begin
            defaults();
            for (int i = 0; i < LANES; i++) t_src[i] = rnd_any();
            t_mask = 32'($urandom); t_zero = 1'($urandom);
            t_bc = (n == 4); t_men = (n != 5);
            t_rmd = 2'($urandom); t_rse = 1'($urandom); t_rms = 2'($urandom);
            run_op("R1", 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule